// File: doc/BRIEF.md
# Interrupt Request Acceptance and Status Switch

This block sits beside the control registers of a small processor core and rules on each request an external interrupt controller presents. A request carries the handler entry address, a requested priority level, the shadow register set its handler should run in, and a flag that marks it as nonmaskable. The block weighs the request against the live status word and answers at once. If it accepts, it rewrites the status word on the next clock edge and raises a one-cycle redirect to the handler.

On acceptance the old status word (enable bit, level, current set) is copied into a saved-status register and the old set index is recorded separately. The current set becomes the requested one, the level becomes the requested level, and the enable bit is cleared. Handlers that want nesting set the enable bit again through a set-enable pulse. A return pulse puts the saved word back. Nonmaskable acceptance sets a sticky flag that holds off further nonmaskable requests until a return.

Top module: `irq_accept_unit`

## Requirements
- R1: A request without the nonmaskable flag is accepted only when the status enable bit is 1 and its requested level is strictly greater than the status level; an equal or lower level, or a cleared enable bit, refuses it.
- R2: A request with the nonmaskable flag is accepted whatever the enable bit and whatever its level compared with the status level, as long as the nonmaskable-active flag is 0.
- R3: Accepting a nonmaskable request sets the nonmaskable-active flag. While that flag is 1, nonmaskable requests are refused. A return pulse clears it.
- R4: One cycle after an acceptance, the current set equals the requested set index if that index is below NUM_SETS, and 0 otherwise.
- R5: One cycle after an acceptance, the enable bit is 0. A set-enable pulse in a cycle with neither an acceptance nor a return makes it 1 on the next cycle. Reset leaves the enable bit, level, set, saved word, previous set and nonmaskable-active flag all at 0.
- R6: One cycle after an acceptance, the saved-status outputs hold the enable bit, level and set that were current in the accepting cycle, and the previous-set output holds that same set.
- R7: One cycle after an acceptance, the status level equals the accepted request's level.
- R8: The redirect valid output is 1 in exactly the cycle after an acceptance, with the redirect address equal to the accepted handler address; otherwise it is 0.
- R9: A return pulse without an acceptance in the same cycle loads enable bit, level and set from the saved-status register on the next cycle. If an acceptance happens in the same cycle, the acceptance update wins.
- R10: The accept output is combinational: it reflects the request and the status in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Request present |
| req_addr | input | ADDR_W | Handler entry address |
| req_level | input | 6 | Requested priority level |
| req_set | input | 4 | Requested shadow register set |
| req_nmi | input | 1 | Request is nonmaskable |
| ret_pulse | input | 1 | Return from exception |
| ie_set | input | 1 | Software sets the enable bit |
| req_taken | output | 1 | Request accepted this cycle |
| redirect_valid | output | 1 | Redirect to handler |
| redirect_addr | output | ADDR_W | Redirect target |
| stat_ie | output | 1 | Status enable bit |
| stat_level | output | 6 | Status level |
| stat_set | output | 4 | Current register set |
| saved_ie | output | 1 | Saved enable bit |
| saved_level | output | 6 | Saved level |
| saved_set | output | 4 | Saved set |
| prev_set | output | 4 | Set in use before last acceptance |
| nmi_active | output | 1 | Nonmaskable handler running |

## Verification
The accept output is due in the same cycle as the request, so the driver checks it a short delay after changing the inputs, before the clock edge. The status, saved word, previous set, flag and redirect outputs all come from a single register stage. They are due one cycle after the stimulus. The driver queues its model's prediction after that edge, and the monitor pops and compares it at the following falling edge.

// File: rtl/iau_pkg.sv
package iau_pkg;
  localparam int LVL_W = 6;
  localparam int SET_W = 4;

  typedef logic [LVL_W-1:0] lvl_t;
  typedef logic [SET_W-1:0] set_t;

  typedef struct packed {
    logic ie;
    lvl_t lvl;
    set_t rset;
  } iau_stat_t;

  // maskable path: enable bit and strictly higher level
  function automatic logic iau_mask_ok(logic ie, lvl_t req, lvl_t cur);
    return ie && (req > cur);
  endfunction

  // unimplemented sets fall back to set 0
  function automatic set_t iau_map_set(set_t s, int unsigned nsets);
    return (32'(s) < nsets) ? s : '0;
  endfunction
endpackage

// File: rtl/iau_gate.sv
module iau_gate
  import iau_pkg::*;
(
  input  logic      req_valid,
  input  logic      req_nmi,
  input  lvl_t      req_level,
  input  iau_stat_t cur,
  input  logic      nmi_busy,
  output logic      take
);
  logic mask_path;
  logic nmi_path;

  always_comb begin
    mask_path = !req_nmi && iau_mask_ok(cur.ie, req_level, cur.lvl);
    nmi_path  = req_nmi && !nmi_busy;
    take      = req_valid && (mask_path || nmi_path);
  end
endmodule

// File: rtl/iau_status.sv
module iau_status
  import iau_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      acc_ev,
  input  logic      acc_nmi,
  input  logic      ret_ev,
  input  logic      ie_set,
  input  lvl_t      new_lvl,
  input  set_t      new_set,
  output iau_stat_t cur,
  output iau_stat_t saved,
  output set_t      prev_set,
  output logic      nmi_busy
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur      <= '0;
      saved    <= '0;
      prev_set <= '0;
      nmi_busy <= 1'b0;
    end else if (acc_ev) begin
      saved    <= cur;
      prev_set <= cur.rset;
      cur.ie   <= 1'b0;
      cur.lvl  <= new_lvl;
      cur.rset <= new_set;
      if (acc_nmi) nmi_busy <= 1'b1;
    end else if (ret_ev) begin
      cur      <= saved;
      nmi_busy <= 1'b0;
    end else if (ie_set) begin
      cur.ie <= 1'b1;
    end
  end
endmodule

// File: rtl/iau_redirect.sv
module iau_redirect #(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_ev,
  input  logic [ADDR_W-1:0] tgt,
  output logic              valid,
  output logic [ADDR_W-1:0] addr
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid <= 1'b0;
      addr  <= '0;
    end else begin
      valid <= acc_ev;
      if (acc_ev) addr <= tgt;
    end
  end
endmodule

// File: rtl/irq_accept_unit.sv
module irq_accept_unit
  import iau_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int NUM_SETS = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [5:0]        req_level,
  input  logic [3:0]        req_set,
  input  logic              req_nmi,
  input  logic              ret_pulse,
  input  logic              ie_set,
  output logic              req_taken,
  output logic              redirect_valid,
  output logic [ADDR_W-1:0] redirect_addr,
  output logic              stat_ie,
  output logic [5:0]        stat_level,
  output logic [3:0]        stat_set,
  output logic              saved_ie,
  output logic [5:0]        saved_level,
  output logic [3:0]        saved_set,
  output logic [3:0]        prev_set,
  output logic              nmi_active
);
  iau_stat_t cur, saved;
  set_t      prev_q;
  logic      nmi_busy;

  // named internal events
  logic acc_ev;
  logic acc_nmi;
  logic ret_ev;
  set_t mapped_set;

  assign mapped_set = iau_map_set(req_set, NUM_SETS);

  iau_gate u_gate (
    .req_valid (req_valid),
    .req_nmi   (req_nmi),
    .req_level (req_level),
    .cur       (cur),
    .nmi_busy  (nmi_busy),
    .take      (acc_ev)
  );

  assign acc_nmi = acc_ev && req_nmi;
  assign ret_ev  = ret_pulse && !acc_ev;

  iau_status u_stat (
    .clk      (clk),
    .rst_n    (rst_n),
    .acc_ev   (acc_ev),
    .acc_nmi  (acc_nmi),
    .ret_ev   (ret_ev),
    .ie_set   (ie_set),
    .new_lvl  (req_level),
    .new_set  (mapped_set),
    .cur      (cur),
    .saved    (saved),
    .prev_set (prev_q),
    .nmi_busy (nmi_busy)
  );

  iau_redirect #(.ADDR_W(ADDR_W)) u_redir (
    .clk    (clk),
    .rst_n  (rst_n),
    .acc_ev (acc_ev),
    .tgt    (req_addr),
    .valid  (redirect_valid),
    .addr   (redirect_addr)
  );

  assign req_taken   = acc_ev;
  assign stat_ie     = cur.ie;
  assign stat_level  = cur.lvl;
  assign stat_set    = cur.rset;
  assign saved_ie    = saved.ie;
  assign saved_level = saved.lvl;
  assign saved_set   = saved.rset;
  assign prev_set    = prev_q;
  assign nmi_active  = nmi_busy;
endmodule

// File: rtl/iau_checker.sv
module iau_checker #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_taken,
  input logic              req_nmi,
  input logic [5:0]        req_level,
  input logic [ADDR_W-1:0] req_addr,
  input logic              ret_pulse,
  input logic              redirect_valid,
  input logic [ADDR_W-1:0] redirect_addr,
  input logic              stat_ie,
  input logic [5:0]        stat_level,
  input logic [5:0]        saved_level,
  input logic              nmi_active
);
  // R1
  mask_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_taken && !req_nmi) |-> (stat_ie && (req_level > stat_level)));

  // R3
  nmi_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_taken && req_nmi) |-> !nmi_active);

  // R5
  ie_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_taken |=> !stat_ie);

  // R7
  level_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_taken |=> (stat_level == $past(req_level)));

  // R6
  save_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_taken |=> (saved_level == $past(stat_level)));

  // R8
  redirect_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_taken |=> (redirect_valid && (redirect_addr == $past(req_addr))));

  // R8
  redirect_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req_taken |=> !redirect_valid);

  // R9
  restore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_pulse && !req_taken) |=> (stat_level == $past(saved_level)));
endmodule

bind irq_accept_unit iau_checker #(.ADDR_W(ADDR_W)) u_iau_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .req_taken      (req_taken),
  .req_nmi        (req_nmi),
  .req_level      (req_level),
  .req_addr       (req_addr),
  .ret_pulse      (ret_pulse),
  .redirect_valid (redirect_valid),
  .redirect_addr  (redirect_addr),
  .stat_ie        (stat_ie),
  .stat_level     (stat_level),
  .saved_level    (saved_level),
  .nmi_active     (nmi_active)
);

// File: tb/tb_irq_accept_unit.sv
`timescale 1ns/1ps
module tb_irq_accept_unit;
  localparam int AW = 32;
  localparam int NS = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [5:0]    req_level = '0;
  logic [3:0]    req_set = '0;
  logic          req_nmi = 1'b0;
  logic          ret_pulse = 1'b0;
  logic          ie_set = 1'b0;
  logic          req_taken, redirect_valid, stat_ie, saved_ie, nmi_active;
  logic [AW-1:0] redirect_addr;
  logic [5:0]    stat_level, saved_level;
  logic [3:0]    stat_set, saved_set, prev_set;

  always #2 clk = ~clk;

  irq_accept_unit #(.ADDR_W(AW), .NUM_SETS(NS)) dut (.*);

  typedef struct {
    string         tag;
    logic          rv;
    logic [AW-1:0] ra;
    logic          ie;
    logic [5:0]    lv;
    logic [3:0]    st;
    logic          sie;
    logic [5:0]    slv;
    logic [3:0]    sst;
    logic [3:0]    pst;
    logic          nm;
  } exp_t;

  exp_t q[$];
  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  // bench model of status
  logic       m_ie = 0, m_sie = 0, m_nmi = 0;
  logic [5:0] m_lv = 0, m_slv = 0;
  logic [3:0] m_st = 0, m_sst = 0, m_pst = 0;
  logic [AW-1:0] m_ra = 0;

  task automatic fld(string tag, string nm, int act, int exp);
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, nm, act, exp);
    end
  endtask

  task automatic cmp(exp_t e);
    checks++;
    fld(e.tag, "redirect_valid", redirect_valid, e.rv);
    if (e.rv) fld(e.tag, "redirect_addr", redirect_addr, e.ra);
    fld(e.tag, "stat_ie", stat_ie, e.ie);
    fld(e.tag, "stat_level", stat_level, e.lv);
    fld(e.tag, "stat_set", stat_set, e.st);
    fld(e.tag, "saved_ie", saved_ie, e.sie);
    fld(e.tag, "saved_level", saved_level, e.slv);
    fld(e.tag, "saved_set", saved_set, e.sst);
    fld(e.tag, "prev_set", prev_set, e.pst);
    fld(e.tag, "nmi_active", nmi_active, e.nm);
  endtask

  // driver: one cycle of stimulus, same-cycle accept check, queue prediction
  task automatic step(string tag, logic v, logic [AW-1:0] a, logic [5:0] l,
                      logic [3:0] s, logic n, logic r, logic ies);
    logic tk;
    exp_t e;
    @(negedge clk);
    req_valid = v; req_addr = a; req_level = l; req_set = s;
    req_nmi = n; ret_pulse = r; ie_set = ies;
    tk = v && (n ? !m_nmi : (m_ie && (l > m_lv)));
    #1;
    checks++;
    if (req_taken !== tk) begin // R10 same-cycle accept
      fails++;
      $display("FAIL %s R10 req_taken actual=%0d expected=%0d", tag, req_taken, tk);
    end
    if (tk) begin
      m_sie = m_ie; m_slv = m_lv; m_sst = m_st; m_pst = m_st;
      m_ie = 0; m_lv = l; m_st = (s < NS) ? s : 4'd0;
      if (n) m_nmi = 1;
      m_ra = a;
    end else if (r) begin
      m_ie = m_sie; m_lv = m_slv; m_st = m_sst; m_nmi = 0;
    end else if (ies) begin
      m_ie = 1;
    end
    e = '{tag, tk, m_ra, m_ie, m_lv, m_st, m_sie, m_slv, m_sst, m_pst, m_nmi};
    @(posedge clk);
    q.push_back(e);
  endtask

  // monitor
  always @(negedge clk) begin
    if (q.size() > 0) cmp(q.pop_front());
  end

  initial begin
    #(4 * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    exp_t e0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    // R5 reset state
    e0 = '{"R5 reset", 0, 0, 0, 0, 0, 0, 0, 0, 0, 0};
    #1 cmp(e0);
    step("R1 ie clear blocks", 1, 32'h100, 6'd9, 4'd1, 0, 0, 0);
    step("R5 ie set", 0, 0, 0, 0, 0, 0, 1);
    step("R1 equal level blocks", 1, 32'h104, 6'd0, 4'd1, 0, 0, 0);
    step("R4 R6 R7 R8 accept", 1, 32'h2000, 6'd5, 4'd2, 0, 0, 0);
    step("R8 idle after", 0, 0, 0, 0, 0, 0, 0);
    step("R1 ie cleared after accept", 1, 32'h3000, 6'd20, 4'd3, 0, 0, 0);
    step("R5 re-enable", 0, 0, 0, 0, 0, 0, 1);
    step("R1 equal level 5 blocks", 1, 32'h3004, 6'd5, 4'd1, 0, 0, 0);
    step("R4 unimplemented set", 1, 32'h4000, 6'd6, 4'd7, 0, 0, 0);
    step("R2 nmi low level ie off", 1, 32'h5000, 6'd1, 4'd3, 1, 0, 0);
    step("R3 nmi blocked", 1, 32'h5100, 6'd40, 4'd1, 1, 0, 0);
    step("R9 return restores", 0, 0, 0, 0, 0, 1, 0);
    step("R3 nmi after return", 1, 32'h6000, 6'd2, 4'd1, 1, 0, 0);
    step("R9 return", 0, 0, 0, 0, 0, 1, 0);
    step("R5 enable", 0, 0, 0, 0, 0, 0, 1);
    step("R9 accept beats return", 1, 32'h7000, 6'd30, 4'd3, 0, 1, 0);
    step("R9 plain return", 0, 0, 0, 0, 0, 1, 0);
    step("R8 idle", 0, 0, 0, 0, 0, 0, 0);
    @(negedge clk);
    req_valid = 0; ret_pulse = 0; ie_set = 0;
    repeat (2) @(negedge clk);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule